// File: doc/BRIEF.md
# Sixteen-bit bus slave byte-lane steering

This block is the memory-cycle data path of a 16-bit slave on a bus with a 24-bit address and a 16-bit data bus. The data bus has two byte lanes: bits 7:0 form the low lane and bits 15:8 form the high lane. The block decodes a fixed memory window. It holds the window's shared byte buffer as two 8-bit banks, one for even offsets and one for odd offsets. It tells the requester combinationally whether the slave can take a 16-bit transfer at the current address.

A cycle begins when the address-latch strobe falls. At that point the block captures the address, the memory/IO qualifier, the direction and the high-byte enable. The command strobe then opens the data phase. On a read, the block drives the whole even-aligned byte pair and the requester takes the lane it wants. On a write, the block stores each lane on its own, controlled by address bit 0 and the high-byte enable. The one forbidden lane combination stores nothing and is recorded in a sticky flag and a saturating counter. Transceiver enables for the data and address buffers are produced here as well.

Top module: `byte_lane_steer`

## Requirements
- R1: `ds16_no` is low in the same cycle, with no clock edge involved, exactly when `mio_i`=1 (memory cycle) and `addr_i` lies in [BASE, BASE+2^WIN_AW). It is high for I/O cycles (`mio_i`=0) and for addresses outside the window.
- R2: A cycle's address, `mio_i`, `wr_i` and `sbhe_ni` are captured at the first rising clock edge at which `adl_ni` is sampled low after being high. Changes to these inputs after that edge do not affect the cycle.
- R3: While a captured in-window memory read (`wr_i`=0) has `cmd_ni` low, `data_oe_o`=1 and `data_o` = {buf[base+1], buf[base]}. Here base is the in-window offset with bit 0 cleared. This holds for every value of address bit 0 and `sbhe_ni`.
- R4: `data_oe_o`=0 and `data_o`=0 whenever no captured in-window memory read has `cmd_ni` low. This covers writes, I/O cycles, misses and an inactive command.
- R5: On each rising edge with `cmd_ni` low in a captured in-window memory write, `data_i[7:0]` is stored to buf[base] if and only if address bit 0 is 0.
- R6: On the same edges, `data_i[15:8]` is stored to buf[base+1] if and only if `sbhe_ni`=0. This decision does not depend on the low-lane decision.
- R7: The combination `sbhe_ni`=1 with address bit 0 = 1, in a captured in-window memory cycle, is forbidden. It writes no buffer byte. From the capturing edge onward it sets `err_sticky_o` and adds 1 to `err_cnt_o`, once per cycle. The counter stops at 2^CNT_W-1.
- R8: `dxcvr_en_no` is low exactly while a captured in-window memory cycle has `cmd_ni` low. `axcvr_en_no` is always the complement of `dxcvr_en_no`.
- R9: Asserting `rst_ni` low clears the captured cycle at once. This removes the read drive and the transceiver enable, and clears `err_sticky_o` and `err_cnt_o`. Buffer contents are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | AW | Unlatched bus address |
| mio_i | input | 1 | 1 = memory cycle, 0 = I/O cycle |
| wr_i | input | 1 | 1 = write, 0 = read |
| sbhe_ni | input | 1 | High-byte enable, active low |
| adl_ni | input | 1 | Address-latch strobe, active low |
| cmd_ni | input | 1 | Command (data phase) strobe, active low |
| data_i | input | 16 | Write data from the bus |
| data_o | output | 16 | Read data to the bus |
| data_oe_o | output | 1 | Read data drive enable |
| ds16_no | output | 1 | 16-bit capable indication, active low |
| dxcvr_en_no | output | 1 | Data transceiver enable, active low |
| axcvr_en_no | output | 1 | Address transceiver enable, active low |
| err_sticky_o | output | 1 | Forbidden lane combination seen |
| err_cnt_o | output | CNT_W | Saturating count of forbidden cycles |

## Verification
Two functions can act in the same data phase: the combinational size indication, which follows the live address, and the read drive or lane writes, which follow the captured address. The bench sets the address, qualifier, direction and enable to random values as soon as the command strobe falls. It then checks `ds16_no` against the new address while it checks `data_o`, `data_oe_o` and the stored bytes against the captured ones. Forbidden-combination counting is also checked in the cycle that writes, by reading back both bytes of the pair afterwards.

// File: rtl/ls_pkg.sv
package ls_pkg;
  // encoding is {sbhe_n, a0}
  typedef enum logic [1:0] {
    LANE_WORD = 2'b00,
    LANE_HI   = 2'b01,
    LANE_LO   = 2'b10,
    LANE_BAD  = 2'b11
  } lane_e;

  function automatic lane_e lane_of(input logic sbhe_n, input logic a0);
    return lane_e'({sbhe_n, a0});
  endfunction
endpackage

// File: rtl/ls_win_decode.sv
module ls_win_decode #(
  parameter int          AW     = 24,
  parameter int          WIN_AW = 11,
  parameter logic [23:0] BASE   = 24'hD0000
) (
  input  logic [AW-1:WIN_AW] tag_i,
  input  logic               mio_i,
  output logic               hit_o
);
  localparam logic [AW-WIN_AW-1:0] BASE_TAG = BASE[AW-1:WIN_AW];

  assign hit_o = mio_i && (tag_i == BASE_TAG);
endmodule

// File: rtl/ls_cycle_latch.sv
module ls_cycle_latch
  import ls_pkg::*;
#(
  parameter int WIN_AW = 11,
  parameter int CNT_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              adl_ni,
  input  logic              hit_i,
  input  logic [WIN_AW-1:0] off_i,
  input  logic              sbhe_ni,
  input  logic              wr_i,
  output logic              hit_o,
  output logic              wr_o,
  output logic [WIN_AW-2:0] idx_o,
  output lane_e             lane_o,
  output logic              err_o,
  output logic [CNT_W-1:0]  cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic  adl_q;
  logic  start;
  lane_e lane_d;

  assign start  = !adl_ni && adl_q;
  assign lane_d = lane_of(sbhe_ni, off_i[0]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      adl_q  <= 1'b1;
      hit_o  <= 1'b0;
      wr_o   <= 1'b0;
      idx_o  <= '0;
      lane_o <= LANE_WORD;
      err_o  <= 1'b0;
      cnt_o  <= '0;
    end else begin
      adl_q <= adl_ni;
      if (start) begin
        hit_o  <= hit_i;
        wr_o   <= wr_i;
        idx_o  <= off_i[WIN_AW-1:1];
        lane_o <= lane_d;
        if (hit_i && lane_d == LANE_BAD) begin
          err_o <= 1'b1;
          if (cnt_o != CNT_MAX) cnt_o <= cnt_o + 1'b1;
        end
      end
    end
  end

  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o); // R7
  AST_CNT_SATURATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_o == CNT_MAX) |=> (cnt_o == CNT_MAX)); // R7
  AST_CNT_NEEDS_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_o != '0) |-> err_o); // R7
endmodule

// File: rtl/ls_lane_buffer.sv
module ls_lane_buffer #(
  parameter int WIN_AW = 11
) (
  input  logic              clk_i,
  input  logic [1:0]        we_i,
  input  logic [WIN_AW-2:0] idx_i,
  input  logic [15:0]       wdata_i,
  output logic [15:0]       rdata_o
);
  localparam int DEPTH = 2 ** (WIN_AW - 1);

  for (genvar g = 0; g < 2; g++) begin : g_lane
    logic [7:0] bank [DEPTH];

    always_ff @(posedge clk_i) begin
      if (we_i[g]) bank[idx_i] <= wdata_i[g*8 +: 8];
    end

    assign rdata_o[g*8 +: 8] = bank[idx_i];
  end
endmodule

// File: rtl/byte_lane_steer.sv
module byte_lane_steer
  import ls_pkg::*;
#(
  parameter int          AW     = 24,
  parameter int          WIN_AW = 11,
  parameter logic [23:0] BASE   = 24'hD0000,
  parameter int          CNT_W  = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [AW-1:0]    addr_i,
  input  logic             mio_i,
  input  logic             wr_i,
  input  logic             sbhe_ni,
  input  logic             adl_ni,
  input  logic             cmd_ni,
  input  logic [15:0]      data_i,
  output logic [15:0]      data_o,
  output logic             data_oe_o,
  output logic             ds16_no,
  output logic             dxcvr_en_no,
  output logic             axcvr_en_no,
  output logic             err_sticky_o,
  output logic [CNT_W-1:0] err_cnt_o
);
  logic              live_hit;
  logic              lat_hit;
  logic              lat_wr;
  logic [WIN_AW-2:0] lat_idx;
  lane_e             lat_lane;
  logic              cmd_act;
  logic              rd_act;
  logic              wr_act;
  logic [1:0]        we;
  logic [15:0]       rdata;

  ls_win_decode #(.AW(AW), .WIN_AW(WIN_AW), .BASE(BASE)) u_dec (
    .tag_i (addr_i[AW-1:WIN_AW]),
    .mio_i (mio_i),
    .hit_o (live_hit)
  );

  ls_cycle_latch #(.WIN_AW(WIN_AW), .CNT_W(CNT_W)) u_lat (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .adl_ni  (adl_ni),
    .hit_i   (live_hit),
    .off_i   (addr_i[WIN_AW-1:0]),
    .sbhe_ni (sbhe_ni),
    .wr_i    (wr_i),
    .hit_o   (lat_hit),
    .wr_o    (lat_wr),
    .idx_o   (lat_idx),
    .lane_o  (lat_lane),
    .err_o   (err_sticky_o),
    .cnt_o   (err_cnt_o)
  );

  // size indication follows the live address, never the latch
  assign ds16_no = !live_hit;

  assign cmd_act = !cmd_ni && lat_hit;
  assign rd_act  = cmd_act && !lat_wr;
  assign wr_act  = cmd_act && lat_wr;

  // low lane on even address, high lane on high-byte enable
  assign we[0] = wr_act && !lat_lane[0];
  assign we[1] = wr_act && !lat_lane[1];

  ls_lane_buffer #(.WIN_AW(WIN_AW)) u_buf (
    .clk_i   (clk_i),
    .we_i    (we),
    .idx_i   (lat_idx),
    .wdata_i (data_i),
    .rdata_o (rdata)
  );

  assign data_oe_o   = rd_act;
  assign data_o      = rd_act ? rdata : '0;
  assign dxcvr_en_no = !cmd_act;
  assign axcvr_en_no = cmd_act;

  AST_DS16_IO_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mio_i |-> ds16_no); // R1
  AST_NO_BAD_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lat_lane == LANE_BAD) |-> (we == 2'b00)); // R7
  AST_WE_IN_CMD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we != 2'b00) |-> (!cmd_ni && !dxcvr_en_no)); // R5
  AST_OE_XCVR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_oe_o |-> (!dxcvr_en_no && we == 2'b00)); // R8
  AST_BAD_SETS_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lat_hit && lat_lane == LANE_BAD) |-> err_sticky_o); // R7
endmodule

// File: tb/tb_byte_lane_steer.sv
module tb_byte_lane_steer;
  localparam int          AW     = 24;
  localparam int          WIN_AW = 11;
  localparam int          WIN_SZ = 2 ** WIN_AW;
  localparam logic [23:0] BASE   = 24'hD0000;
  localparam int          CNT_W  = 4;
  localparam int          CMAX   = 2 ** CNT_W - 1;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic mio_i = 1'b0, wr_i = 1'b0, sbhe_ni = 1'b1, adl_ni = 1'b1, cmd_ni = 1'b1;
  logic [15:0] data_i = '0;
  logic [15:0] data_o;
  logic data_oe_o, ds16_no, dxcvr_en_no, axcvr_en_no, err_sticky_o;
  logic [CNT_W-1:0] err_cnt_o;

  int checks = 0, fails = 0;
  logic [7:0] ref_mem [WIN_SZ];
  bit exp_err = 0;
  int exp_cnt = 0;

  byte_lane_steer #(.AW(AW), .WIN_AW(WIN_AW), .BASE(BASE), .CNT_W(CNT_W)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr_i), .mio_i(mio_i), .wr_i(wr_i),
    .sbhe_ni(sbhe_ni), .adl_ni(adl_ni), .cmd_ni(cmd_ni), .data_i(data_i),
    .data_o(data_o), .data_oe_o(data_oe_o), .ds16_no(ds16_no),
    .dxcvr_en_no(dxcvr_en_no), .axcvr_en_no(axcvr_en_no),
    .err_sticky_o(err_sticky_o), .err_cnt_o(err_cnt_o)
  );

  always #5 clk = ~clk;

  function automatic bit in_win(input logic [23:0] a);
    return a >= BASE && a < BASE + WIN_SZ;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  // one bus cycle; inputs are scrambled as soon as the command strobe falls
  task automatic bus_cycle(input logic [23:0] a, input bit mio, input bit sbhe_n,
                           input bit wr, input logic [15:0] wd);
    bit hit = mio && in_win(a);
    int base = int'(a[WIN_AW-1:0]) & ~1;
    logic [15:0] exp_rd;
    @(negedge clk);
    addr_i = a; mio_i = mio; sbhe_ni = sbhe_n; wr_i = wr; data_i = wd;
    adl_ni = 1'b0; cmd_ni = 1'b1;
    #1 chk(ds16_no == !hit, "R1", "ds16_no setup", ds16_no, !hit);
    chk(data_oe_o == 1'b0, "R4", "oe before cmd", data_oe_o, 0);
    @(negedge clk);
    adl_ni = 1'b1; cmd_ni = 1'b0;
    addr_i = $urandom; mio_i = $urandom; sbhe_ni = $urandom; wr_i = $urandom;
    if (hit && sbhe_n && a[0]) begin
      exp_err = 1;
      if (exp_cnt < CMAX) exp_cnt++;
    end
    #1;
    chk(ds16_no == !(mio_i && in_win(addr_i)), "R1", "ds16_no live", ds16_no,
        !(mio_i && in_win(addr_i)));
    chk(err_sticky_o == exp_err, "R7", "err flag", err_sticky_o, exp_err);
    chk(err_cnt_o == exp_cnt[CNT_W-1:0], "R7", "err count", err_cnt_o, exp_cnt);
    chk(data_oe_o == (hit && !wr), "R2", "oe from latched cycle", data_oe_o, hit && !wr);
    chk(dxcvr_en_no == !hit, "R8", "data xcvr", dxcvr_en_no, !hit);
    chk(axcvr_en_no == !dxcvr_en_no, "R8", "addr xcvr", axcvr_en_no, !dxcvr_en_no);
    if (hit && !wr) begin
      exp_rd = {ref_mem[base+1], ref_mem[base]};
      chk(data_o == exp_rd, "R3", "read pair", data_o, exp_rd);
    end else begin
      chk(data_o == 16'h0, "R4", "idle data", data_o, 0);
    end
    @(negedge clk);
    cmd_ni = 1'b1;
    if (hit && wr) begin
      if (!a[0])   ref_mem[base]   = wd[7:0];   // R5
      if (!sbhe_n) ref_mem[base+1] = wd[15:8];  // R6
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=expired expected=done");
    report();
  end

  initial begin
    logic [23:0] a;
    bit sb;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    #1;
    chk(data_oe_o == 0 && dxcvr_en_no == 1 && axcvr_en_no == 0, "R9", "reset outputs",
        {data_oe_o, dxcvr_en_no, axcvr_en_no}, 3'b010);
    chk(err_sticky_o == 0 && err_cnt_o == 0, "R9", "reset errors", err_cnt_o, 0);
    rst_ni = 1'b1;

    // fill buffer with full words
    for (int i = 0; i < WIN_SZ / 2; i++) bus_cycle(BASE + 24'(2 * i), 1, 0, 1, 16'($urandom));

    // directed: high-only write at odd address, then read both ways (R6, R3)
    bus_cycle(BASE + 24'h11, 1, 0, 1, 16'hA55A);
    bus_cycle(BASE + 24'h11, 1, 0, 0, 16'h0);
    bus_cycle(BASE + 24'h10, 1, 1, 0, 16'h0);
    // low-only write at even address (R5)
    bus_cycle(BASE + 24'h20, 1, 1, 1, 16'h3CC3);
    bus_cycle(BASE + 24'h20, 1, 0, 0, 16'h0);
    // forbidden write leaves both bytes (R7)
    bus_cycle(BASE + 24'h31, 1, 1, 1, 16'hFFFF);
    bus_cycle(BASE + 24'h30, 1, 0, 0, 16'h0);
    // I/O cycle inside window is ignored (R1, R4)
    bus_cycle(BASE + 24'h40, 0, 0, 1, 16'h1234);
    bus_cycle(BASE + 24'h40, 1, 0, 0, 16'h0);
    // window edges (R1)
    bus_cycle(BASE - 24'h1, 1, 0, 0, 16'h0);
    bus_cycle(BASE + 24'(WIN_SZ - 2), 1, 0, 0, 16'h0);
    bus_cycle(BASE + 24'(WIN_SZ), 1, 0, 1, 16'hBEEF);

    // constrained random
    for (int n = 0; n < 800; n++) begin
      a = ($urandom % 4 != 0) ? BASE + 24'($urandom % WIN_SZ) : 24'($urandom);
      sb = $urandom;
      if ($urandom % 10 == 0) begin sb = 1; a[0] = 1; end
      else if (sb) a[0] = 0;
      bus_cycle(a, ($urandom % 8) != 0, sb, $urandom, 16'($urandom));
    end

    // saturation (R7)
    for (int i = 0; i < CMAX + 2; i++) bus_cycle(BASE + 24'h51, 1, 1, 0, 16'h0);
    chk(err_cnt_o == CMAX[CNT_W-1:0], "R7", "count saturated", err_cnt_o, CMAX);

    // reset during an active read (R9)
    @(negedge clk);
    addr_i = BASE + 24'h60; mio_i = 1; wr_i = 0; sbhe_ni = 0; adl_ni = 0;
    @(negedge clk);
    adl_ni = 1; cmd_ni = 0;
    #1 chk(data_oe_o == 1, "R3", "oe before reset", data_oe_o, 1);
    rst_ni = 0;
    #1;
    chk(data_oe_o == 0 && dxcvr_en_no == 1, "R9", "reset drops drive",
        {data_oe_o, dxcvr_en_no}, 2'b01);
    chk(err_sticky_o == 0 && err_cnt_o == 0, "R9", "reset clears errors", err_cnt_o, 0);
    @(negedge clk);
    cmd_ni = 1; rst_ni = 1;
    exp_err = 0; exp_cnt = 0;
    bus_cycle(BASE + 24'h60, 1, 0, 0, 16'h0);  // R9 buffer kept
    report();
  end
endmodule